// File: doc/BRIEF.md
# Selectable Power-of-Two Moving Average

This block is a streaming boxcar filter for signed 14-bit samples. Each sample that arrives with its strobe is stored in a history buffer and added to a running sum. The sample that has just left the window is subtracted from the same sum. The block registers the sum, shifted arithmetically right by M, as the average one cycle later. The window holds 2^M samples, and every tap has the same weight. Because every window length is a power of two, the division is a shift and needs no divider.

M comes from the low four bits of a 16-bit control word. The block ignores the upper twelve bits and limits M to 8, which gives 256 taps. A change of the effective M restarts the filter: the history and the sum are dropped, and results come back only once a full new window has been collected. A caller sets the control word, streams samples with the strobe, and takes each result when its valid flag is high.

Top module: `pow2_boxcar_avg`

## Requirements
- R1: After reset the window exponent is 4 (16 taps), no result is flagged valid, and the window is empty.
- R2: The effective exponent is taken from control bits 3:0 only. Changing bits 15:4 while bits 3:0 stay the same does not restart the filter.
- R3: A requested exponent above 8 acts as 8. Moving between two requests that both resolve to 8 (for example 8, 12 and 15) does not restart the filter.
- R4: Each sample accepted with the strobe yields, on the next cycle, the average of the most recent 2^M accepted samples, all taps weighted equally.
- R5: After reset or a restart, no result is flagged valid until 2^M samples have been accepted. The first valid result comes with the 2^M-th sample.
- R6: A change of the effective exponent clears the history and the sum. A sample whose strobe coincides with the change is discarded and produces no result. Valid is low in the cycle after the change.
- R7: With M equal to 0, every result equals its input sample, one cycle later.
- R8: The average is the signed window sum shifted right arithmetically, so it rounds toward negative infinity (for example, the pair -1, 0 averages to -1 and the pair 1, 0 averages to 0).
- R9: Valid is high only in the cycle after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Control word; bits 3:0 request the window exponent |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed two's complement sample |
| out_valid | output | 1 | Result strobe, one cycle after an accepted sample |
| out_avg | output | 14 | Signed window average |

## Verification
The bench drives the block through changes of the window length. It checks that restarts happen only when the effective exponent changes. A design that decoded the upper control bits, or that compared the raw field before clamping, would drop its window when it should not, and the results it then withheld would be missing from the scoreboard. The bench also places a sample in the same cycle as an exponent change. It fills the 256-tap window completely with full-scale negative and positive samples, which would expose a sum too narrow to hold the total or a wrap of the buffer pointer that is off by one. Odd-sum windows of negative values check that the rounding goes toward negative infinity and not toward zero.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

   // Resolve a requested window exponent against the largest legal one.
   function automatic int unsigned resolve_log(input int unsigned req,
                                               input int unsigned lim);
      return (req > lim) ? lim : req;
   endfunction

   // Bits needed to hold the values 0..n.
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/boxcar_ctrl.sv
module boxcar_ctrl #(
   parameter int unsigned MW      = 4,
   parameter int unsigned MAX_LOG = 8,
   parameter int unsigned RST_LOG = 4,
   localparam int unsigned LW     = boxcar_pkg::bits_for(MAX_LOG),
   localparam int unsigned CW     = MAX_LOG + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] cfg_m,
   input  logic          in_valid,
   output logic [LW-1:0] m_cur,
   output logic          clr,
   output logic          accept,
   output logic          full,
   output logic          fill_done
);

   localparam int unsigned FIELD_MAX = (1 << MW) - 1;

   logic [LW-1:0] m_req;
   logic [CW-1:0] taps;
   logic [CW-1:0] cnt;

   if (RST_LOG > MAX_LOG) begin : g_bad_rst
      $error("boxcar_ctrl: RST_LOG exceeds MAX_LOG");
   end

   // Clamp only when the field can encode values past the limit.
   if (FIELD_MAX > MAX_LOG) begin : g_clamp
      always_comb begin
         m_req = LW'(boxcar_pkg::resolve_log(int'(cfg_m), MAX_LOG));
      end
   end else begin : g_direct
      always_comb begin
         m_req = LW'(cfg_m);
      end
   end

   assign clr       = (m_req != m_cur);
   assign accept    = in_valid && !clr;
   assign taps      = CW'(1) << m_cur;
   assign full      = (cnt == taps);
   assign fill_done = (cnt >= (taps - CW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cur <= LW'(RST_LOG);
         cnt   <= '0;
      end else if (clr) begin
         m_cur <= m_req;
         cnt   <= '0;
      end else if (accept && !full) begin
         cnt   <= cnt + CW'(1);
      end
   end

   // R3: the exponent in use never passes the limit
   a_r3_exp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(m_cur) <= MAX_LOG);

   // R6: a restart leaves the fill count at zero
   a_r6_fill_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/boxcar_hist.sv
module boxcar_hist #(
   parameter int unsigned DW      = 14,
   parameter int unsigned MAX_LOG = 8,
   localparam int unsigned LW     = boxcar_pkg::bits_for(MAX_LOG),
   localparam int unsigned AW     = MAX_LOG,
   localparam int unsigned DEPTH  = 1 << AW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic signed [DW-1:0] wr_data,
   input  logic [LW-1:0]        m_cur,
   output logic signed [DW-1:0] oldest
);

   logic signed [DW-1:0] mem [DEPTH];
   logic [AW-1:0]        wp;
   logic [AW:0]          span;
   logic [AW-1:0]        rp;

   if (MAX_LOG < 1) begin : g_bad_depth
      $error("boxcar_hist: MAX_LOG must be at least 1");
   end

   // A full-depth window wraps the span to zero, which reads the slot
   // about to be overwritten: the sample written DEPTH strobes ago.
   assign span   = (AW+1)'(1) << m_cur;
   assign rp     = wp - span[AW-1:0];
   assign oldest = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
      end else if (wr_en) begin
         wp <= wp + AW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wp] <= wr_data;
      end
   end

endmodule

// File: rtl/boxcar_sum.sv
module boxcar_sum #(
   parameter int unsigned DW      = 14,
   parameter int unsigned MAX_LOG = 8,
   localparam int unsigned LW     = boxcar_pkg::bits_for(MAX_LOG),
   localparam int unsigned SW     = DW + MAX_LOG
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 accept,
   input  logic                 full,
   input  logic                 fill_done,
   input  logic [LW-1:0]        m_cur,
   input  logic signed [DW-1:0] new_s,
   input  logic signed [DW-1:0] old_s,
   output logic signed [DW-1:0] avg,
   output logic                 avg_valid
);

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] add_term;
   logic signed [SW-1:0] sub_term;
   logic signed [SW-1:0] sum_next;
   logic signed [SW-1:0] shifted;

   assign add_term = {{MAX_LOG{new_s[DW-1]}}, new_s};
   assign sub_term = full ? {{MAX_LOG{old_s[DW-1]}}, old_s} : '0;
   assign sum_next = sum + add_term - sub_term;
   assign shifted  = sum_next >>> m_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum       <= '0;
         avg       <= '0;
         avg_valid <= 1'b0;
      end else if (clr) begin
         sum       <= '0;
         avg_valid <= 1'b0;
      end else begin
         avg_valid <= accept && fill_done;
         if (accept) begin
            sum <= sum_next;
            avg <= shifted[DW-1:0];
         end
      end
   end

   // R6: the running sum is empty after a restart
   a_r6_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum == '0));

endmodule

// File: rtl/pow2_boxcar_avg.sv
module pow2_boxcar_avg #(
   parameter int unsigned DW      = 14,
   parameter int unsigned CFGW    = 16,
   parameter int unsigned MW      = 4,
   parameter int unsigned MAX_LOG = 8,
   parameter int unsigned RST_LOG = 4,
   localparam int unsigned LW     = boxcar_pkg::bits_for(MAX_LOG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CFGW-1:0]      cfg_word,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_avg
);

   logic [LW-1:0]        m_cur;
   logic                 clr;
   logic                 accept;
   logic                 full;
   logic                 fill_done;
   logic signed [DW-1:0] oldest;

   if (MW > CFGW) begin : g_bad_field
      $error("pow2_boxcar_avg: exponent field wider than control word");
   end

   boxcar_ctrl #(
      .MW      (MW),
      .MAX_LOG (MAX_LOG),
      .RST_LOG (RST_LOG)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_m     (cfg_word[MW-1:0]),
      .in_valid  (in_valid),
      .m_cur     (m_cur),
      .clr       (clr),
      .accept    (accept),
      .full      (full),
      .fill_done (fill_done)
   );

   boxcar_hist #(
      .DW      (DW),
      .MAX_LOG (MAX_LOG)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .wr_data (in_sample),
      .m_cur   (m_cur),
      .oldest  (oldest)
   );

   boxcar_sum #(
      .DW      (DW),
      .MAX_LOG (MAX_LOG)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .accept    (accept),
      .full      (full),
      .fill_done (fill_done),
      .m_cur     (m_cur),
      .new_s     (in_sample),
      .old_s     (oldest),
      .avg       (out_avg),
      .avg_valid (out_valid)
   );

   // R9: a result only follows an accepted strobe
   a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(accept));

   // R6: no result in the cycle after a restart
   a_r6_quiet_after_change: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);

   // R7: a single-tap window passes the sample straight through
   a_r7_single_tap_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (m_cur == '0)) |=> (out_valid && (out_avg == $past(in_sample))));

endmodule

// File: tb/tb_pow2_boxcar_avg.sv
`timescale 1ns/1ps
module tb_pow2_boxcar_avg;

   typedef struct {
      int    value;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [15:0]        cfg_word = 16'h0004;
   logic               in_valid = 1'b0;
   logic signed [13:0] in_sample = '0;
   logic               out_valid;
   logic signed [13:0] out_avg;

   int    checks = 0;
   int    errors = 0;
   exp_t  sb[$];
   int    hist[$];
   int    m_model = 4;
   int    lcg = 12345;
   string tag_force = "";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   pow2_boxcar_avg dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_word  (cfg_word),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .out_valid (out_valid),
      .out_avg   (out_avg)
   );

   function automatic int next_rand();
      lcg = lcg * 1103515245 + 12345;
      return ((lcg >>> 8) & 16'h3fff) - 8192;
   endfunction

   // Driver: applies one cycle of stimulus and predicts its result.
   task automatic drive(input logic [15:0] cfg, input bit v, input int x);
      int newm;
      @(negedge clk);
      cfg_word  = cfg;
      in_valid  = v;
      in_sample = x[13:0];
      newm = (int'(cfg[3:0]) > 8) ? 8 : int'(cfg[3:0]);
      if (newm != m_model) begin
         m_model = newm;          // R6: restart; a coinciding sample is dropped
         hist.delete();
      end else if (v) begin
         hist.push_back(x);
         if (hist.size() > 256) void'(hist.pop_front());
         if (hist.size() >= (1 << m_model)) begin
            int s;
            exp_t e;
            s = 0;
            for (int i = 0; i < (1 << m_model); i++) s += hist[hist.size()-1-i];
            e.value = s >>> m_model;
            e.tag   = (tag_force != "") ? tag_force : ((m_model == 0) ? "R7" : "R4");
            sb.push_back(e);
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(cfg_word, 1'b0, 0);
   endtask

   task automatic stream(input logic [15:0] cfg, input int n);
      for (int i = 0; i < n; i++) drive(cfg, 1'b1, next_rand());
   endtask

   // Monitor: compares each result with the oldest prediction.
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R5/R9 unexpected result: actual %0d expected none", out_avg);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (int'(out_avg) != e.value) begin
               errors++;
               $display("FAIL %s average: actual %0d expected %0d", e.tag, out_avg, e.value);
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 valid during reset: actual %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 valid after reset: actual %b expected 0", out_valid);
      end

      // R1, R4, R5: default 16-tap window filling from empty
      stream(16'h0004, 40);
      idle(3);

      // R2: upper bits change, same exponent, no restart
      stream(16'hfff4, 10);
      stream(16'h5a04, 10);

      // R9: gaps between strobes
      for (int i = 0; i < 8; i++) begin
         drive(16'h0004, 1'b1, next_rand());
         idle(2);
      end

      // R7: single tap
      stream(16'h0000, 20);

      // R8: rounding toward negative infinity, two taps
      drive(16'h0001, 1'b0, 0);
      tag_force = "R8";
      drive(16'h0001, 1'b1, -1);
      drive(16'h0001, 1'b1, 0);    // -1,0 -> -1
      drive(16'h0001, 1'b1, 1);    // 0,1 -> 0
      drive(16'h0001, 1'b1, -8);
      drive(16'h0001, 1'b1, -7);   // -15/2 -> -8
      drive(16'h0001, 1'b1, -6);   // -13/2 -> -7
      tag_force = "";
      stream(16'h0003, 30);

      // R6: change coinciding with a sample
      drive(16'h0002, 1'b1, 1234);
      stream(16'h0002, 12);
      drive(16'h0005, 1'b1, -77);
      stream(16'h0005, 40);

      // R3: clamp to 8, moves between clamped values keep the window
      stream(16'h0009, 300);
      stream(16'h000f, 40);
      stream(16'h0008, 40);
      stream(16'h000c, 40);

      // R4: full-scale extremes in the widest window
      for (int i = 0; i < 300; i++) drive(16'h0008, 1'b1, -8192);
      for (int i = 0; i < 300; i++) drive(16'h0008, 1'b1, 8191);
      stream(16'h0007, 200);

      idle(4);
      done = 1'b1;
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R5 missing results: actual %0d pending expected 0", sb.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule